// File: doc/BRIEF.md
# Interrupt Event Status Collector

This block gathers single-cycle event pulses from a bus-level event detector and a transaction engine into one 32-bit status word. Each status bit stays set until software writes a one to clear it. A small enable register selects which of the four summary sources may raise the single interrupt request line. The detectors that produce the pulses are outside this block.

The sources are:
- a bus-state change (suspend entered or resume seen);
- a transaction summary, which covers setup, IN, acknowledged OUT and isochronous traffic on any endpoint;
- cable attach;
- wake-up;
- one flag per endpoint;
- a setup-packet flag.

Some clear paths are linked on purpose. A clear of the transaction summary also wipes every endpoint flag. Clearing any endpoint flag, or the setup flag, also drops the summary. Software can therefore handle the summary and its details in either order.

Top module: `irq_event_agg`

## Requirements
- R1: After a synchronous active-low reset, the status word, the enable word and the interrupt request are all 0.
- R2: An event pulse sets its status bit one cycle later: bus-state change at bit 0, transaction summary at bit 1, attach at bit 2, wake-up at bit 3, endpoint n at bit 16+n (n = 0 to 7), setup at bit 31. Status bits 4 to 15 and 24 to 30 always read 0.
- R3: A status write (select = 0) with a 1 in a bit position clears that bit. A 0 in a position leaves that bit unchanged.
- R4: A status write with a 1 at bit 1 also clears all endpoint bits 16 to 23.
- R5: Status bit 1 is also cleared by a status write with a 1 at bit 31 or at any of bits 16 to 23.
- R6: The setup bit 31 is cleared only by a 1 at bit 31. A write of 1 at bit 1 leaves it set. A 1 at bit 31 does not clear endpoint bits.
- R7: When an event pulse and a clear hit the same status bit in the same cycle, the bit ends up set.
- R8: A write with select = 1 loads the enable word from data bits 3:0. Status writes never change the enable word, and enable writes never change the status word.
- R9: The interrupt request is a registered OR of status bits 3:0 ANDed with enable bits 3:0. It follows the status word by one cycle.
- R10: Endpoint bits and the setup bit never raise the interrupt request on their own, even with all enables set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_bus_i | input | 1 | Bus-state change pulse |
| ev_xfer_i | input | 1 | Transaction summary pulse |
| ev_attach_i | input | 1 | Attach pulse |
| ev_wake_i | input | 1 | Wake-up pulse |
| ev_ep_i | input | NUM_EP | Per-endpoint event pulses |
| ev_setup_i | input | 1 | Setup packet pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 = status, 1 = enable |
| wr_data_i | input | 32 | Write data |
| status_o | output | 32 | Status word |
| enable_o | output | 4 | Enable word |
| irq_o | output | 1 | Interrupt request |

## Verification
Timing relative to the clock edge that samples a stimulus (an event pulse or a write):
- Status and enable words change at that same edge, so each check reads them one cycle after the stimulus.
- The interrupt request follows one edge later, two cycles after the stimulus.

The bench drives inputs on the falling edge and samples on the next falling edge, so every reading falls midway between edges at the cycle where the result is due. For the interrupt path, the bench also checks the intermediate cycle, where status has moved but the request has not yet changed. Same-cycle set and clear collisions are driven in one single cycle, so the set-wins rule is tested exactly as stated.

// File: rtl/irq_agg_pkg.sv
// Package: fixed bit positions of the status word and the write-target code.
// Assumes a 32-bit status word with the four summary sources in bits 3:0.
package irq_agg_pkg;
    localparam int STAT_W    = 32;
    localparam int N_TOP     = 4;
    localparam int POS_BUS   = 0;
    localparam int POS_XFER  = 1;
    localparam int POS_ATT   = 2;
    localparam int POS_WAKE  = 3;
    localparam int POS_SETUP = 31;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_ENABLE = 1'b1
    } wr_target_e;
endpackage

// File: rtl/irq_w1c_bit.sv
// One sticky status bit: a set pulse raises it, a clear request lowers it.
// Assumes set and clear are already decoded; set has priority over clear.
module irq_w1c_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q_q;

    // Hold the flag; set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     q_q <= 1'b0;
        else if (set_i) q_q <= 1'b1;
        else if (clr_i) q_q <= 1'b0;
    end

    assign q_o = q_q;

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
    // R3
    clr_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);
    // R3
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/irq_clear_map.sv
// Decodes a status write into per-bit clear requests, including the linked
// clears between the summary bit, the endpoint bits and the setup bit.
// Assumes wr_stat_i is already qualified by the write strobe and target.
module irq_clear_map
    import irq_agg_pkg::*;
#(
    parameter int NUM_EP  = 8,
    parameter int EP_BASE = 16
) (
    input  logic              wr_stat_i,
    input  logic [STAT_W-1:0] wr_data_i,
    output logic [N_TOP-1:0]  clr_top_o,
    output logic [NUM_EP-1:0] clr_ep_o,
    output logic              clr_setup_o
);
    localparam logic [STAT_W-1:0] EP_MASK   = ((STAT_W'(1) << NUM_EP) - STAT_W'(1)) << EP_BASE;
    localparam logic [STAT_W-1:0] USED_MASK = EP_MASK | (STAT_W'(1) << POS_SETUP)
                                            | ((STAT_W'(1) << N_TOP) - STAT_W'(1));

    logic any_ep_hit;
    logic unused_wr_bits;

    // Fold data bits that have no meaning so every input bit is consumed.
    assign unused_wr_bits = ^(wr_data_i & ~USED_MASK);
    assign any_ep_hit     = |(wr_data_i & EP_MASK);

    // Per-source clear requests with the linked summary paths.
    always_comb begin
        clr_top_o           = '0;
        clr_top_o[POS_BUS]  = wr_stat_i & wr_data_i[POS_BUS];
        clr_top_o[POS_XFER] = wr_stat_i & (wr_data_i[POS_XFER] | wr_data_i[POS_SETUP] | any_ep_hit);
        clr_top_o[POS_ATT]  = wr_stat_i & wr_data_i[POS_ATT];
        clr_top_o[POS_WAKE] = wr_stat_i & wr_data_i[POS_WAKE];
        clr_setup_o         = wr_stat_i & wr_data_i[POS_SETUP];
    end

    // Endpoint clears: own position, or the summary position.
    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep_clr
        assign clr_ep_o[i] = wr_stat_i & (wr_data_i[EP_BASE+i] | wr_data_i[POS_XFER]);
    end
endmodule

// File: rtl/irq_enable_gate.sv
// Enable register for the four summary sources and the registered request.
// Assumes the summary status bits arrive straight from their flip-flops.
module irq_enable_gate
    import irq_agg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [N_TOP-1:0] wr_bits_i,
    input  logic [N_TOP-1:0] top_stat_i,
    output logic [N_TOP-1:0] en_o,
    output logic             irq_o
);
    logic [N_TOP-1:0] en_q;
    logic             irq_q;

    // Load the enable word on an enable write.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (wr_en_i) en_q <= wr_bits_i;
    end

    // Register the gated OR of the summary flags.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(top_stat_i & en_q);
    end

    assign en_o  = en_q;
    assign irq_o = irq_q;

    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(top_stat_i & en_o)) |=> irq_o);
    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(top_stat_i & en_o)) |=> !irq_o);
    // R8
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(en_o));
endmodule

// File: rtl/irq_event_agg.sv
// Top: collects event pulses into a write-one-to-clear status word, holds the
// enable word and drives one interrupt request.
// Assumes event inputs are single-cycle pulses in the clk domain and that
// EP_BASE + NUM_EP does not reach the setup bit.
module irq_event_agg
    import irq_agg_pkg::*;
#(
    parameter int NUM_EP  = 8,
    parameter int EP_BASE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_bus_i,
    input  logic              ev_xfer_i,
    input  logic              ev_attach_i,
    input  logic              ev_wake_i,
    input  logic [NUM_EP-1:0] ev_ep_i,
    input  logic              ev_setup_i,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [STAT_W-1:0] wr_data_i,
    output logic [STAT_W-1:0] status_o,
    output logic [N_TOP-1:0]  enable_o,
    output logic              irq_o
);
    logic              wr_stat, wr_en_reg;
    logic [N_TOP-1:0]  set_top, clr_top, top_q;
    logic [NUM_EP-1:0] clr_ep, ep_q;
    logic              clr_setup, setup_q;

    assign wr_stat   = wr_en_i && (wr_target_e'(wr_sel_i) == SEL_STATUS);
    assign wr_en_reg = wr_en_i && (wr_target_e'(wr_sel_i) == SEL_ENABLE);
    assign set_top   = {ev_wake_i, ev_attach_i, ev_xfer_i, ev_bus_i};

    irq_clear_map #(.NUM_EP(NUM_EP), .EP_BASE(EP_BASE)) i_clr (
        .wr_stat_i  (wr_stat),
        .wr_data_i  (wr_data_i),
        .clr_top_o  (clr_top),
        .clr_ep_o   (clr_ep),
        .clr_setup_o(clr_setup)
    );

    for (genvar t = 0; t < N_TOP; t++) begin : g_top
        irq_w1c_bit i_bit (.clk(clk), .rst_n(rst_n), .set_i(set_top[t]),
                           .clr_i(clr_top[t]), .q_o(top_q[t]));
    end

    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        irq_w1c_bit i_bit (.clk(clk), .rst_n(rst_n), .set_i(ev_ep_i[e]),
                           .clr_i(clr_ep[e]), .q_o(ep_q[e]));
    end

    irq_w1c_bit i_setup (.clk(clk), .rst_n(rst_n), .set_i(ev_setup_i),
                         .clr_i(clr_setup), .q_o(setup_q));

    irq_enable_gate i_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_reg),
        .wr_bits_i (wr_data_i[N_TOP-1:0]),
        .top_stat_i(top_q),
        .en_o      (enable_o),
        .irq_o     (irq_o)
    );

    // Assemble the status word; undefined positions stay 0.
    always_comb begin
        status_o                          = '0;
        status_o[N_TOP-1:0]               = top_q;
        status_o[EP_BASE +: NUM_EP]       = ep_q;
        status_o[POS_SETUP]               = setup_q;
    end

    // R5
    setup_drops_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wr_data_i[POS_SETUP] && !ev_xfer_i) |=> !status_o[POS_XFER]);
    // R4
    xfer_wipes_ep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wr_data_i[POS_XFER] && !(|ev_ep_i)) |=> (status_o[EP_BASE +: NUM_EP] == '0));
    // R6
    setup_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[POS_SETUP] && !(wr_stat && wr_data_i[POS_SETUP])) |=> status_o[POS_SETUP]);
    // R8
    stat_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_reg && !ev_bus_i && !ev_xfer_i && !ev_attach_i && !ev_wake_i
         && !(|ev_ep_i) && !ev_setup_i) |=> $stable(status_o));
endmodule

// File: tb/test_irq_event_agg.sv
module test_irq_event_agg;
    localparam int NEP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_bus = 0, ev_xfer = 0, ev_att = 0, ev_wake = 0, ev_setup = 0;
    logic [NEP-1:0] ev_ep = '0;
    logic        wr_en = 0, wr_sel = 0;
    logic [31:0] wr_data = '0;
    logic [31:0] status;
    logic [3:0]  enable;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_event_agg #(.NUM_EP(NEP), .EP_BASE(16)) i_irq_event_agg (
        .clk(clk), .rst_n(rst_n),
        .ev_bus_i(ev_bus), .ev_xfer_i(ev_xfer), .ev_attach_i(ev_att), .ev_wake_i(ev_wake),
        .ev_ep_i(ev_ep), .ev_setup_i(ev_setup),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .status_o(status), .enable_o(enable), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle of stimulus, applied at a falling edge; returns at the next one.
    // top = {wake, attach, xfer, bus}
    task automatic step(input logic [3:0] top, input logic [NEP-1:0] ep, input logic setup,
                        input logic we, input logic sel, input logic [31:0] d);
        {ev_wake, ev_att, ev_xfer, ev_bus} = top;
        ev_ep = ep; ev_setup = setup; wr_en = we; wr_sel = sel; wr_data = d;
        @(negedge clk);
        {ev_wake, ev_att, ev_xfer, ev_bus} = '0;
        ev_ep = '0; ev_setup = 0; wr_en = 0; wr_sel = 0; wr_data = '0;
    endtask

    task automatic clear_all();
        step(4'h0, '0, 0, 1, 0, 32'hFFFF_FFFF);
        chk("R3 clear all", status, 32'h0);
    endtask

    task automatic t_reset();
        chk("R1 status", status, 32'h0);
        chk("R1 enable", {28'h0, enable}, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_positions();
        logic [31:0] exp = 32'h0;
        step(4'b0001, '0, 0, 0, 0, '0); exp[0] = 1; chk("R2 bus bit", status, exp);
        step(4'b0010, '0, 0, 0, 0, '0); exp[1] = 1; chk("R2 xfer bit", status, exp);
        step(4'b0100, '0, 0, 0, 0, '0); exp[2] = 1; chk("R2 attach bit", status, exp);
        step(4'b1000, '0, 0, 0, 0, '0); exp[3] = 1; chk("R2 wake bit", status, exp);
        for (int i = 0; i < NEP; i++) begin
            step(4'h0, NEP'(1) << i, 0, 0, 0, '0);
            exp[16+i] = 1;
            chk("R2 endpoint bit", status, exp);
        end
        step(4'h0, '0, 1, 0, 0, '0); exp[31] = 1; chk("R2 setup bit", status, exp);
        chk("R2 unused zero", status & 32'h7F00_FFF0, 32'h0);
        clear_all();
    endtask

    task automatic t_own_clear();
        step(4'hF, '0, 0, 0, 0, '0);
        step(4'h0, '0, 0, 1, 0, 32'h0000_0001);
        chk("R3 own clear bit0", status, 32'h0000_000E);
        step(4'h0, '0, 0, 1, 0, 32'h0000_0000);
        chk("R3 zero write no effect", status, 32'h0000_000E);
        step(4'h0, '0, 0, 1, 0, 32'h0000_000C);
        chk("R3 own clear bits 2,3", status, 32'h0000_0002);
        clear_all();
    endtask

    task automatic t_xfer_wipes();
        step(4'b0010, 8'hA5, 1, 0, 0, '0);
        chk("R2 combined set", status, 32'h80A5_0002);
        step(4'h0, '0, 0, 1, 0, 32'h0000_0002);
        chk("R4 R6 bit1 wipes endpoints, setup kept", status, 32'h8000_0000);
        clear_all();
    endtask

    task automatic t_summary_links();
        step(4'b0010, 8'h08, 0, 0, 0, '0);
        step(4'h0, '0, 0, 1, 0, 32'h0008_0000);
        chk("R5 endpoint3 clear drops summary", status, 32'h0);
        step(4'b0010, 8'h20, 1, 0, 0, '0);
        step(4'h0, '0, 0, 1, 0, 32'h8000_0000);
        chk("R5 R6 setup clear drops summary only", status, 32'h0020_0000);
        clear_all();
        step(4'b0010, '0, 0, 0, 0, '0);
        step(4'h0, '0, 0, 1, 0, 32'h0001_0000);
        chk("R5 endpoint0 clear drops summary", status, 32'h0);
    endtask

    task automatic t_set_wins();
        step(4'b0001, '0, 0, 0, 0, '0);
        step(4'b0001, '0, 0, 1, 0, 32'h0000_0001);
        chk("R7 set beats own clear", status, 32'h0000_0001);
        step(4'b0000, 8'h04, 0, 1, 0, 32'h0000_0002);
        chk("R7 endpoint set beats linked clear", status, 32'h0004_0001);
        clear_all();
    endtask

    task automatic t_enable();
        step(4'b0100, '0, 0, 0, 0, '0);
        step(4'h0, '0, 0, 1, 1, 32'hFFFF_FFFA);
        chk("R8 enable load", {28'h0, enable}, 32'hA);
        chk("R8 status untouched by enable write", status, 32'h0000_0004);
        step(4'h0, '0, 0, 1, 0, 32'h0000_0004);
        chk("R8 enable untouched by status write", {28'h0, enable}, 32'hA);
        chk("R3 attach cleared", status, 32'h0);
    endtask

    task automatic t_irq();
        step(4'h0, '0, 0, 1, 1, 32'h1);
        step(4'b1000, '0, 0, 0, 0, '0);
        @(negedge clk);
        chk("R9 masked source no irq", {31'h0, irq}, 32'h0);
        step(4'b0001, '0, 0, 0, 0, '0);
        chk("R9 irq not yet", {31'h0, irq}, 32'h0);
        @(negedge clk);
        chk("R9 irq raised", {31'h0, irq}, 32'h1);
        step(4'h0, '0, 0, 1, 0, 32'h1);
        chk("R9 irq lags clear", {31'h0, irq}, 32'h1);
        @(negedge clk);
        chk("R9 irq dropped", {31'h0, irq}, 32'h0);
        clear_all();
        step(4'h0, '0, 0, 1, 1, 32'hF);
        step(4'h0, 8'hFF, 1, 0, 0, '0);
        @(negedge clk);
        @(negedge clk);
        chk("R10 endpoint and setup no irq", {31'h0, irq}, 32'h0);
        chk("R10 bits held", status, 32'h80FF_0000);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_positions();
        t_own_clear();
        t_xfer_wipes();
        t_summary_links();
        t_set_wins();
        t_enable();
        t_irq();
        finish_run();
    end
endmodule